// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Byte Receiver

This block recovers bytes from a single asynchronous serial line that idles high. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block runs from a master clock at sixteen times the bit rate. The line is never used as a clock. It passes through a two-flop synchroniser and is then treated as ordinary data.

One frame counter times the whole frame. It rests at zero while the line is high and starts on the first master clock edge that sees the synchronised line low. It then runs to the end of its 152-count cycle and returns to zero regardless of the line. A decode of the count places one shift enable at the centre of each data cell. A single later count copies the assembled byte into a holding register, raises a one-cycle valid pulse and records whether the stop bit was low. The host can then read the byte at any point before the next frame completes.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, `rx_byte` is 0x00, `rx_valid` is 0 and `rx_frame_err` is 0.
- R2: While the synchronised line stays high and no frame is in progress, the frame counter stays at zero and no `rx_valid` pulse appears.
- R3: The first data cell after the start bit becomes bit 0 of `rx_byte` and the eighth becomes bit 7 (least significant bit first).
- R4: Each data cell is sampled at its centre: with 16 master clocks per cell, inverting the line for the first 3 and the last 3 clocks of every data cell does not change the received byte.
- R5: Each frame produces exactly one `rx_valid` pulse, one clock wide, at the edge where the 152-count frame counter wraps from 151 to 0.
- R6: `rx_byte` and `rx_frame_err` change only at the edge that raises `rx_valid`, and hold their values until the next frame loads.
- R7: `rx_frame_err` is 1 for a byte if the synchronised line is low at count 151 (inside the stop bit), and 0 otherwise. `rx_valid` still pulses for such a byte.
- R8: A frame whose start bit directly follows the previous stop bit, with no idle time, is received correctly.
- R9: `rx_valid` is sampled high 154 master clocks after the first clock edge that sees the start bit on `rx_line`: 2 synchroniser stages plus 152 counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idles high |
| rx_byte | output | 8 | Holding register with the last received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is loaded |
| rx_frame_err | output | 1 | Stop bit was low for the byte in `rx_byte` |

## Verification
On every cycle, the assertions check the following:
- the counter is held at zero while the line is idle and never leaves its 152-count range;
- `rx_valid` is a single cycle wide and coincides with the counter wrap;
- the holding register and the error flag stay fixed between loads.

Only the bench scenarios can show the remaining behaviour:
- bit order and centre sampling under edge disturbances;
- correct framing-error values;
- back-to-back frames;
- the exact start-to-valid latency.

// File: rtl/rx_pkg.sv
package rx_pkg;
    // Counts from the start edge to the centre of the stop bit.
    function automatic int unsigned frame_len(input int unsigned ovs, input int unsigned nbits);
        return ovs * (nbits + 1) + ovs / 2;
    endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rx_frame_counter.sv
module rx_frame_counter
    import rx_pkg::*;
#(
    parameter int unsigned OVS   = 16,
    parameter int unsigned NBITS = 8,
    localparam int unsigned FRAME_LEN = frame_len(OVS, NBITS),
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    output logic [CNT_W-1:0] cnt,
    output logic             shift_en,
    output logic             load_en
);
    localparam int unsigned HALF  = OVS / 2;
    localparam int unsigned LB    = $clog2(OVS);
    localparam int unsigned FIRST = OVS + HALF;
    localparam int unsigned LAST  = OVS * NBITS + HALF;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0 || !line_s) begin
            if (cnt_q == CNT_W'(FRAME_LEN - 1)) cnt_d = '0;
            else                                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt      = cnt_q;
    assign shift_en = (cnt_q[LB-1:0] == LB'(HALF)) &&
                      (int'(cnt_q) >= int'(FIRST)) && (int'(cnt_q) <= int'(LAST));
    assign load_en  = (cnt_q == CNT_W'(FRAME_LEN - 1));
endmodule

// File: rtl/rx_shift_hold.sv
module rx_shift_hold #(
    parameter int unsigned NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    input  logic             shift_en,
    input  logic             load_en,
    output logic [NBITS-1:0] byte_o,
    output logic             valid_o,
    output logic             ferr_o
);
    typedef struct packed {
        logic [NBITS-1:0] sh;
        logic [NBITS-1:0] hold;
        logic             valid;
        logic             ferr;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (shift_en) st_d.sh = {line_s, st_q.sh[NBITS-1:1]};
        if (load_en) begin
            st_d.hold  = st_q.sh;
            st_d.valid = 1'b1;
            st_d.ferr  = !line_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o  = st_q.hold;
    assign valid_o = st_q.valid;
    assign ferr_o  = st_q.ferr;
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned NBITS       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned FRAME_LEN  = frame_len(OVS, NBITS),
    localparam int unsigned CNT_W      = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    output logic [NBITS-1:0] rx_byte,
    output logic             rx_valid,
    output logic             rx_frame_err
);
    logic             line_sync;
    logic [CNT_W-1:0] frame_cnt;
    logic             shift_en;
    logic             load_en;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_sync)
    );

    rx_frame_counter #(.OVS(OVS), .NBITS(NBITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .line_s(line_sync),
        .cnt(frame_cnt), .shift_en(shift_en), .load_en(load_en)
    );

    rx_shift_hold #(.NBITS(NBITS)) u_sh (
        .clk(clk), .rst_n(rst_n), .line_s(line_sync),
        .shift_en(shift_en), .load_en(load_en),
        .byte_o(rx_byte), .valid_o(rx_valid), .ferr_o(rx_frame_err)
    );
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk #(
    parameter int unsigned NBITS     = 8,
    parameter int unsigned FRAME_LEN = 152,
    parameter int unsigned CNT_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_s,
    input logic [CNT_W-1:0] cnt,
    input logic [NBITS-1:0] rx_byte,
    input logic             rx_valid,
    input logic             rx_frame_err
);
    // R2: idle line keeps the counter at rest
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && line_s) |=> (cnt == '0));

    // R2: counter stays inside its frame range
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < int'(FRAME_LEN));

    // R5: valid is one cycle wide
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: valid coincides with the counter wrap
    a_r5_valid_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (cnt == '0 && int'($past(cnt)) == int'(FRAME_LEN - 1)));

    // R6: holding register stable between loads
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));

    // R7: error flag changes only with a load
    a_r7_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_frame_err));
endmodule

bind serial_byte_rx serial_byte_rx_chk #(
    .NBITS(NBITS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_s(line_sync), .cnt(frame_cnt),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
);

// File: tb/serial_byte_rx_bench.sv
`timescale 1ns/1ps
module serial_byte_rx_bench;
    localparam int OVS = 16;
    localparam int NB  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_frame_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_valid = 0;
    int valid_cyc = 0;
    int start_cyc = 0;
    int double_valid = 0;
    int stray_change = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] cap_byte = '0;
    logic       cap_err = 1'b0;
    logic [7:0] prev_byte = '0;
    logic       prev_err = 1'b0;

    serial_byte_rx u_serial_byte_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                n_valid   = n_valid + 1;
                valid_cyc = cyc;
                cap_byte  = rx_byte;
                cap_err   = rx_frame_err;
                if (prev_valid) double_valid = double_valid + 1;
            end else if (rx_byte !== prev_byte || rx_frame_err !== prev_err) begin
                stray_change = stray_change + 1;
            end
            prev_valid = rx_valid;
            prev_byte  = rx_byte;
            prev_err   = rx_frame_err;
        end
    end

    function automatic int exp_latency();
        return 2 + OVS * (NB + 1) + OVS / 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_cell(input logic v, input bit disturb);
        for (int i = 0; i < OVS; i++) begin
            @(negedge clk);
            rx_line = (disturb && (i < 3 || i >= OVS - 3)) ? ~v : v;
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_stop, input bit disturb);
        @(negedge clk);
        rx_line   = 1'b0;
        start_cyc = cyc;
        for (int i = 1; i < OVS; i++) begin
            @(negedge clk);
            rx_line = 1'b0;
        end
        for (int k = 0; k < NB; k++) drive_cell(b[k], disturb);
        for (int i = 0; i < OVS; i++) begin
            @(negedge clk);
            rx_line = (bad_stop && i < OVS / 2) ? 1'b0 : 1'b1;
        end
    endtask

    task automatic frame_and_check(input logic [7:0] b, input bit bad_stop,
                                   input bit disturb, input string tag);
        int v0;
        v0 = n_valid;
        send_frame(b, bad_stop, disturb);
        check(n_valid == v0 + 1, {tag, " R5 one valid per frame"}, n_valid - v0, 1);
        check(cap_byte == b, {tag, " R3 byte"}, cap_byte, b);
        check(cap_err == bad_stop, {tag, " R7 frame error"}, cap_err, bad_stop);
        check(valid_cyc - start_cyc == exp_latency(), {tag, " R9 latency"},
              valid_cyc - start_cyc, exp_latency());
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int seed;
        int v0;
        logic [7:0] b;
        seed = 32'h5a17;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_byte == 8'h00, "R1 byte after reset", rx_byte, 0);
        check(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
        check(rx_frame_err == 1'b0, "R1 err after reset", rx_frame_err, 0);

        // R2 idle line
        v0 = n_valid;
        repeat (300) @(negedge clk);
        check(n_valid == v0, "R2 no valid while idle", n_valid - v0, 0);

        // Directed frames
        frame_and_check(8'h8D, 1'b0, 1'b0, "dir_lsb");      // R3 bit order
        frame_and_check(8'h01, 1'b0, 1'b0, "dir_b0");       // R3
        frame_and_check(8'h80, 1'b0, 1'b0, "dir_b7");       // R3
        frame_and_check(8'hA5, 1'b0, 1'b1, "dir_r4_edge");  // R4 centre sampling
        frame_and_check(8'h3C, 1'b1, 1'b0, "dir_r7_bad");   // R7 low stop
        frame_and_check(8'h00, 1'b0, 1'b0, "dir_r7_clear"); // R7 flag clears
        // R8 back to back, no idle between frames
        frame_and_check(8'hFF, 1'b0, 1'b0, "dir_r8_a");
        frame_and_check(8'h55, 1'b0, 1'b0, "dir_r8_b");

        // R6 holding register keeps value through idle
        v0 = n_valid;
        repeat (400) @(negedge clk);
        check(rx_byte == 8'h55, "R6 byte held in idle", rx_byte, 8'h55);
        check(n_valid == v0, "R2 idle after frames", n_valid - v0, 0);

        // Random frames
        for (int n = 0; n < 40; n++) begin
            b = 8'($urandom());
            frame_and_check(b, ($urandom() % 8) == 0, ($urandom() % 4) == 0, "rnd");
            repeat ($urandom() % 5) @(negedge clk);
        end

        check(double_valid == 0, "R5 valid one cycle wide", double_valid, 0);
        check(stray_change == 0, "R6 outputs change only with valid", stray_change, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule